// File: doc/BRIEF.md
# Receive Line Status with Per-Character Error Tracking

This block sits behind the bit-level receiver of a 16550-compatible serial port. Every character that the deserializer delivers comes with three error flags (parity, framing, break). The block stores data and flags together, either in a single holding register (character mode) or in a queue (queued mode). It gives software the oldest unread character and a 5-bit line status word.

The error bits in the status word describe the character at the head of the receive path. A bad character that is still waiting behind good ones stays silent. Its flags are reported, and the receiver line status interrupt fires, only in the cycle in which that character becomes the head. Error and overrun bits stay set until software reads the status word. A character that arrives with no room is dropped and raises overrun.

Top module: `rx_status_top`

## Requirements
- R1: After reset, `line_stat` is 0, `ls_irq` is low, `rd_data` is 0, and the block is in character mode.
- R2: `line_stat[0]` (data ready) is high exactly when at least one unread character is held. `rd_data` shows the oldest unread character, and shows 0 when nothing is held. A `data_rd` pulse removes that character. A `data_rd` pulse with nothing held has no effect.
- R3: With `fifo_en` high, up to DEPTH characters are held and are read out in arrival order.
- R4: When a character becomes the head, its flags are OR-ed into the status word: parity into bit 2, framing into bit 3, break into bit 4. A character becomes the head when it arrives into an empty store, or when a read removes the character in front of it. In character mode this means the flags of the character just received.
- R5: In queued mode, a flagged character behind other entries leaves bits 4:2 and `ls_irq` unchanged until the entries in front of it have been read.
- R6: Bit 1 (overrun) is set when `rx_valid` arrives while the store is full: DEPTH entries in queued mode, or one unread entry in character mode. The arriving character is discarded. A `data_rd` in the same cycle does not make room for it.
- R7: Bits 4:1 hold their value until a `stat_rd` pulse clears them. If a new condition for a bit occurs in the same cycle as `stat_rd`, that bit ends up set.
- R8: `ls_irq` is high in the same cycle as any of bits 4:1, and only while `int_en` is high. Clearing `int_en` leaves the status bits unchanged.
- R9: In the first cycle in which `fifo_en` differs from the mode in use, all held characters are discarded. In that cycle, `rx_valid` and `data_rd` are ignored, and bits 4:1 are retained.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | One-cycle strobe: a character was received |
| rx_data | input | DATA_W | Received character |
| rx_par_err | input | 1 | Parity error flag of the received character |
| rx_frm_err | input | 1 | Framing error flag of the received character |
| rx_brk | input | 1 | Break flag of the received character |
| fifo_en | input | 1 | 1 = queued mode, 0 = single holding register |
| int_en | input | 1 | Receiver line status interrupt enable |
| data_rd | input | 1 | Data register read strobe (pops the head) |
| stat_rd | input | 1 | Status word read strobe (clears bits 4:1) |
| rd_data | output | DATA_W | Oldest unread character, 0 when empty |
| line_stat | output | 5 | {break, framing, parity, overrun, data ready} |
| ls_irq | output | 1 | Receiver line status interrupt |

## Verification
The bench builds the block with DEPTH = 4 and DATA_W = 8. With this depth, a full queue, an overrun and every head position can be reached in a few cycles. All seven non-zero flag combinations are placed at every queue slot, so the timing of when each bad character is reported is checked for every position. Flags are also swept through the single holding register with the interrupt both enabled and disabled. Directed steps cover same-cycle read and write at the boundaries, status reads that coincide with new errors, and mode switches with data held.

// File: rtl/rx_stat_pkg.sv
package rx_stat_pkg;

  typedef struct packed {
    logic brk;
    logic frm;
    logic par;
  } rx_err_t;

  localparam int unsigned ERR_W  = 3;
  localparam int unsigned STAT_W = 5;

  localparam int unsigned ST_DR  = 0;
  localparam int unsigned ST_OVR = 1;
  localparam int unsigned ST_PAR = 2;
  localparam int unsigned ST_FRM = 3;
  localparam int unsigned ST_BRK = 4;

endpackage

// File: rtl/rx_err_fifo.sv
module rx_err_fifo
  import rx_stat_pkg::*;
#(
  parameter  int unsigned DATA_W = 8,
  parameter  int unsigned DEPTH  = 16,
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              fifo_mode,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  rx_err_t           push_err,
  input  logic              pop,
  output logic [DATA_W-1:0] head_data,
  output rx_err_t           next_err,
  output logic [CNT_W-1:0]  count,
  output logic              full,
  output logic              empty
);

  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  typedef struct packed {
    rx_err_t           err;
    logic [DATA_W-1:0] data;
  } entry_t;

  entry_t             mem [DEPTH];
  logic [PTR_W-1:0]   wr_ptr_q, wr_ptr_nxt;
  logic [PTR_W-1:0]   rd_ptr_q, rd_ptr_nxt;
  logic [PTR_W-1:0]   rd_ptr_inc, wr_ptr_inc;
  logic [CNT_W-1:0]   cnt_q, cnt_nxt;
  logic [CNT_W-1:0]   cap;

  function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p);
    if (p == PTR_W'(DEPTH - 1)) return '0;
    return p + PTR_W'(1);
  endfunction

  assign cap        = fifo_mode ? CNT_W'(DEPTH) : CNT_W'(1);
  assign full       = (cnt_q >= cap);
  assign empty      = (cnt_q == '0);
  assign count      = cnt_q;
  assign rd_ptr_inc = ptr_step(rd_ptr_q);
  assign wr_ptr_inc = ptr_step(wr_ptr_q);

  always_comb begin
    wr_ptr_nxt = wr_ptr_q;
    rd_ptr_nxt = rd_ptr_q;
    cnt_nxt    = cnt_q;
    if (flush) begin
      wr_ptr_nxt = '0;
      rd_ptr_nxt = '0;
      cnt_nxt    = '0;
    end else begin
      if (push) wr_ptr_nxt = wr_ptr_inc;
      if (pop)  rd_ptr_nxt = rd_ptr_inc;
      cnt_nxt = cnt_q + CNT_W'(push) - CNT_W'(pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_nxt;
      rd_ptr_q <= rd_ptr_nxt;
      cnt_q    <= cnt_nxt;
    end
  end

  // storage carries no reset; content is only observed while counted valid
  always_ff @(posedge clk) begin
    if (push && !flush) mem[wr_ptr_q] <= '{err: push_err, data: push_data};
  end

  assign head_data = mem[rd_ptr_q].data;
  assign next_err  = mem[rd_ptr_inc].err;

endmodule

// File: rtl/rx_line_status.sv
module rx_line_status
  import rx_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stat_rd,
  input  rx_err_t           err_set,
  input  logic              ovr_set,
  input  logic              data_ready,
  input  logic              int_en,
  output logic [STAT_W-1:0] line_stat,
  output logic              ls_irq
);

  rx_err_t err_q, err_nxt;
  logic    ovr_q, ovr_nxt;

  // clear on status read first, then new events win
  always_comb begin
    err_nxt = stat_rd ? rx_err_t'('0) : err_q;
    ovr_nxt = stat_rd ? 1'b0 : ovr_q;
    err_nxt = err_nxt | err_set;
    ovr_nxt = ovr_nxt | ovr_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= '0;
      ovr_q <= 1'b0;
    end else begin
      err_q <= err_nxt;
      ovr_q <= ovr_nxt;
    end
  end

  always_comb begin
    line_stat         = '0;
    line_stat[ST_DR]  = data_ready;
    line_stat[ST_OVR] = ovr_q;
    line_stat[ST_PAR] = err_q.par;
    line_stat[ST_FRM] = err_q.frm;
    line_stat[ST_BRK] = err_q.brk;
  end

  assign ls_irq = int_en & (ovr_q | err_q.par | err_q.frm | err_q.brk);

endmodule

// File: rtl/rx_status_top.sv
module rx_status_top
  import rx_stat_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_par_err,
  input  logic              rx_frm_err,
  input  logic              rx_brk,
  input  logic              fifo_en,
  input  logic              int_en,
  input  logic              data_rd,
  input  logic              stat_rd,
  output logic [DATA_W-1:0] rd_data,
  output logic [STAT_W-1:0] line_stat,
  output logic              ls_irq
);

  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic              mode_q;
  logic              mode_chg;
  logic              accept, ovr_evt, pop;
  logic              fifo_full, fifo_empty, head_single;
  logic [CNT_W-1:0]  fifo_cnt;
  logic [DATA_W-1:0] head_data;
  rx_err_t           in_err, next_err, head_set;

  assign mode_chg = fifo_en ^ mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= 1'b0;
    else        mode_q <= fifo_en;
  end

  assign in_err      = '{brk: rx_brk, frm: rx_frm_err, par: rx_par_err};
  assign accept      = rx_valid & ~fifo_full & ~mode_chg;
  assign ovr_evt     = rx_valid &  fifo_full & ~mode_chg;
  assign pop         = data_rd  & ~fifo_empty & ~mode_chg;
  assign head_single = (fifo_cnt == CNT_W'(1));

  // flags of whichever entry becomes the head at this edge
  always_comb begin
    head_set = '0;
    if (accept && (fifo_empty || (pop && head_single))) head_set = in_err;
    else if (pop && !head_single)                     head_set = next_err;
  end

  rx_err_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (mode_chg),
    .fifo_mode (fifo_en),
    .push      (accept),
    .push_data (rx_data),
    .push_err  (in_err),
    .pop       (pop),
    .head_data (head_data),
    .next_err  (next_err),
    .count     (fifo_cnt),
    .full      (fifo_full),
    .empty     (fifo_empty)
  );

  rx_line_status u_stat (
    .clk        (clk),
    .rst_n      (rst_n),
    .stat_rd    (stat_rd),
    .err_set    (head_set),
    .ovr_set    (ovr_evt),
    .data_ready (~fifo_empty),
    .int_en     (int_en),
    .line_stat  (line_stat),
    .ls_irq     (ls_irq)
  );

  assign rd_data = fifo_empty ? '0 : head_data;

endmodule

// File: rtl/rx_status_chk.sv
module rx_status_chk
  import rx_stat_pkg::*;
#(
  parameter  int unsigned DATA_W = 8,
  parameter  int unsigned DEPTH  = 16,
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_valid,
  input logic              fifo_en,
  input logic              int_en,
  input logic              data_rd,
  input logic              stat_rd,
  input logic              mode_q,
  input logic [CNT_W-1:0]  fifo_cnt,
  input logic [DATA_W-1:0] rd_data,
  input logic [STAT_W-1:0] line_stat,
  input logic              ls_irq
);

  logic at_cap;
  assign at_cap = fifo_en ? (fifo_cnt >= CNT_W'(DEPTH)) : (fifo_cnt != '0);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= CNT_W'(DEPTH)); // R3

  AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !line_stat[ST_DR] |-> (rd_data == '0)); // R2

  AST_OVR_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && (fifo_en == mode_q) && at_cap) |=> line_stat[ST_OVR]); // R6

  AST_SINGLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en && !mode_q) |-> (fifo_cnt <= CNT_W'(1))); // R6

  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_rd |=> ((line_stat[4:1] & $past(line_stat[4:1])) == $past(line_stat[4:1]))); // R7

  AST_CLEAR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !rx_valid && !data_rd) |=> (line_stat[4:1] == '0)); // R7

  AST_IRQ_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    !int_en |-> !ls_irq); // R8

  AST_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en != mode_q) |=> !line_stat[ST_DR]); // R9

endmodule

bind rx_status_top rx_status_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rx_valid  (rx_valid),
  .fifo_en   (fifo_en),
  .int_en    (int_en),
  .data_rd   (data_rd),
  .stat_rd   (stat_rd),
  .mode_q    (mode_q),
  .fifo_cnt  (fifo_cnt),
  .rd_data   (rd_data),
  .line_stat (line_stat),
  .ls_irq    (ls_irq)
);

// File: tb/sim_rx_status_top.sv
`timescale 1ns/1ps
module sim_rx_status_top;

  localparam int D = 4;

  logic       clk, rst_n;
  logic       rx_valid, rx_par_err, rx_frm_err, rx_brk;
  logic [7:0] rx_data;
  logic       fifo_en, int_en, data_rd, stat_rd;
  logic [7:0] rd_data;
  logic [4:0] line_stat;
  logic       ls_irq;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // model state
  logic [10:0] mq[$];
  logic [2:0]  m_err;
  logic        m_ovr;
  logic        m_mode;

  rx_status_top #(.DATA_W(8), .DEPTH(D)) u0 (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err), .rx_brk(rx_brk),
    .fifo_en(fifo_en), .int_en(int_en), .data_rd(data_rd), .stat_rd(stat_rd),
    .rd_data(rd_data), .line_stat(line_stat), .ls_irq(ls_irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input int act, input int exp, input string tag, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic check_outs(input string tag);
    logic [7:0] e_rd;
    logic [4:0] e_st;
    e_rd = (mq.size() > 0) ? mq[0][7:0] : 8'h00;
    e_st = {m_err, m_ovr, mq.size() > 0};
    chk(rd_data, e_rd, tag, "rd_data");
    chk(line_stat, e_st, tag, "line_stat");
    chk(ls_irq, int_en & ((m_err != 0) | m_ovr), tag, "ls_irq");
  endtask

  // f = {brk, frm, par}
  task automatic step(input logic rv, input logic [7:0] d, input logic [2:0] f,
                      input logic dr, input logic sr, input string tag);
    int cap;
    logic full, chg, acc, ovr, pp;
    logic [2:0] set;
    @(negedge clk);
    rx_valid = rv; rx_data = d; rx_brk = f[2]; rx_frm_err = f[1]; rx_par_err = f[0];
    data_rd = dr; stat_rd = sr;
    cap  = fifo_en ? D : 1;
    chg  = (fifo_en != m_mode);
    full = (mq.size() >= cap);
    acc  = rv && !full && !chg;
    ovr  = rv && full && !chg;
    pp   = dr && (mq.size() > 0) && !chg;
    set  = 3'b000;
    if (pp) begin
      void'(mq.pop_front());
      if (mq.size() > 0) set = mq[0][10:8];
    end
    if (acc) begin
      mq.push_back({f, d});
      if (mq.size() == 1) set = f;
    end
    if (chg) begin
      mq.delete();
      m_mode = fifo_en;
    end
    m_err = (sr ? 3'b000 : m_err) | set;
    m_ovr = (sr ? 1'b0 : m_ovr) | ovr;
    @(posedge clk);
    #1;
    check_outs(tag);
  endtask

  task automatic idle(input string tag);
    step(1'b0, 8'h00, 3'b000, 1'b0, 1'b0, tag);
  endtask

  initial begin
    rst_n = 1'b0; rx_valid = 0; rx_data = 0; rx_par_err = 0; rx_frm_err = 0;
    rx_brk = 0; fifo_en = 0; int_en = 1; data_rd = 0; stat_rd = 0;
    m_err = 0; m_ovr = 0; m_mode = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(line_stat, 0, "R1", "line_stat");
    chk(ls_irq, 0, "R1", "ls_irq");
    chk(rd_data, 0, "R1", "rd_data");
    @(negedge clk);
    rst_n = 1'b1;
    idle("R1");

    // R4 R8: every flag combination through the holding register, irq on and off
    for (int ie = 0; ie < 2; ie++) begin
      int_en = ie[0];
      for (int f = 0; f < 8; f++) begin
        step(1'b1, 8'hA0 + 8'(f), 3'(f), 1'b0, 1'b0, "R4");
        idle("R8");
        step(1'b0, 8'h00, 3'b000, 1'b1, 1'b0, "R2");
        step(1'b0, 8'h00, 3'b000, 1'b0, 1'b1, "R7");
      end
    end
    int_en = 1'b1;

    // R2: read on empty has no effect
    step(1'b0, 8'h00, 3'b000, 1'b1, 1'b0, "R2");

    // R6: character mode overrun, read in same cycle does not make room
    step(1'b1, 8'h11, 3'b000, 1'b0, 1'b0, "R6");
    step(1'b1, 8'h22, 3'b001, 1'b0, 1'b0, "R6");
    step(1'b1, 8'h33, 3'b000, 1'b1, 1'b0, "R6");
    step(1'b0, 8'h00, 3'b000, 1'b0, 1'b1, "R7");

    // R9: switch to queued mode with a character held and overrun set
    step(1'b1, 8'h44, 3'b000, 1'b0, 1'b0, "R9");
    step(1'b1, 8'h55, 3'b000, 1'b0, 1'b0, "R9");
    fifo_en = 1'b1;
    step(1'b1, 8'h66, 3'b010, 1'b1, 1'b0, "R9");
    idle("R9");
    step(1'b0, 8'h00, 3'b000, 1'b0, 1'b1, "R7");

    // R5 R3: flagged character at each slot, all non-zero flag values
    for (int pos = 0; pos < D; pos++) begin
      for (int f = 1; f < 8; f++) begin
        for (int k = 0; k < D; k++)
          step(1'b1, 8'(pos * 16 + k * 4 + f), (k == pos) ? 3'(f) : 3'b000,
               1'b0, 1'b0, "R5");
        for (int k = 0; k < D; k++)
          step(1'b0, 8'h00, 3'b000, 1'b1, 1'b0, "R3");
        step(1'b0, 8'h00, 3'b000, 1'b0, 1'b1, "R7");
      end
    end

    // R6 R3: queued overrun, discarded characters, order kept
    for (int k = 0; k < D + 2; k++)
      step(1'b1, 8'(8'hC0 + k), 3'b000, 1'b0, 1'b0, "R6");
    step(1'b1, 8'hEE, 3'b100, 1'b1, 1'b0, "R6");
    for (int k = 0; k < D; k++)
      step(1'b0, 8'h00, 3'b000, 1'b1, 1'b0, "R3");
    step(1'b0, 8'h00, 3'b000, 1'b0, 1'b1, "R7");

    // R4: pop last and push flagged in the same cycle
    step(1'b1, 8'h01, 3'b000, 1'b0, 1'b0, "R4");
    step(1'b1, 8'h02, 3'b011, 1'b1, 1'b0, "R4");
    step(1'b0, 8'h00, 3'b000, 1'b1, 1'b1, "R7");

    // R7: status read coinciding with new error and with overrun
    step(1'b1, 8'h03, 3'b100, 1'b0, 1'b1, "R7");
    step(1'b0, 8'h00, 3'b000, 1'b0, 1'b1, "R7");
    for (int k = 0; k < D - 1; k++)
      step(1'b1, 8'(8'h10 + k), 3'b000, 1'b0, 1'b0, "R6");
    step(1'b1, 8'h20, 3'b000, 1'b0, 1'b1, "R7");
    step(1'b0, 8'h00, 3'b000, 1'b0, 1'b1, "R7");

    // R8: mask and unmask with bits held
    int_en = 1'b0;
    idle("R8");
    int_en = 1'b1;
    idle("R8");
    step(1'b0, 8'h00, 3'b000, 1'b0, 1'b1, "R8");

    // R9: back to character mode, queue flushed, bits kept
    step(1'b1, 8'h77, 3'b000, 1'b0, 1'b0, "R6");
    fifo_en = 1'b0;
    step(1'b0, 8'h00, 3'b000, 1'b1, 1'b0, "R9");
    step(1'b1, 8'h78, 3'b001, 1'b0, 1'b0, "R4");
    idle("R2");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule